// File: doc/BRIEF.md
# FIFO Flag Offset Programmer

This block holds the two threshold offsets that a FIFO uses for its almost-empty and almost-full flags. While reset is held, three strap inputs (the load strobe and two select bits) choose one of eight default offset pairs. They also fix which programming path is enabled for the rest of the session: a bit-serial stream or parallel words. A further strap chooses whether parallel words carry interleaved parity bits that must be stepped over.

After reset, the load strobe acts as a mode switch. While it is high the FIFO may be accessed, and the offsets are frozen. While it is low the offsets can be rewritten through the path chosen at reset, and they can always be read back as parallel words. Successive parallel accesses alternate between the empty offset and the full offset. The block runs on one system clock. The serial clock is an ordinary input that is sampled, and its rising edges are detected in the system clock domain, so it must stay high and low for at least one system clock period each.

Top module: `flag_ofs_prog`

## Requirements
- R1: While `rst_i` is high at a clock edge, both offsets load the default 2^(k+3)-1 (truncated to OFS_W bits), where k = 4*ld_i + 2*fsel_i[1] + fsel_i[0]. Both offsets therefore hold the same value right after reset.
- R2: The programming path is latched at reset: `ld_i` high selects serial and `ld_i` low selects parallel. Only the latched path can modify the offsets.
- R3: In serial mode, each rising edge of `sclk_i` seen while both `sen_i` and `ld_i` are low writes `sdi_i` into one offset bit. The first OFS_W bits fill the empty offset, least significant bit first. The next OFS_W bits fill the full offset in the same order.
- R4: After 2*OFS_W serial bits, the next serial bit goes back to bit 0 of the empty offset.
- R5: While `sen_i` is high, or while `ld_i` is high, serial clock edges leave both offsets unchanged.
- R6: In parallel mode, a clock edge with `ld_i` low and `pwr_i` high writes one offset. Successive writes alternate, starting with the empty offset. `pwr_i` has no effect while `ld_i` is high.
- R7: When the parity strap `ip_i` was high at reset, parallel words skip data bits 8, 17, 26 and 35: offset bit i comes from data bit i + floor(i/8). With the strap low, offset bit i comes from data bit i. All other data bits are ignored in both cases.
- R8: In either mode, a clock edge with `ld_i` low and `prd_i` high places one offset on `pdata_o` after that edge. Successive reads alternate, starting with the empty offset. The read-back word uses the same bit layout as R7, with all other bits zero.
- R9: Reset returns the write and read alternation to the empty offset and restarts the serial bit count at bit 0 of the empty offset.
- R10: `fifo_ok_o` is high exactly while `ld_i` is high and `rst_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high; straps are captured while it is high |
| ld_i | input | 1 | Strap at reset; afterwards, low opens offset access and high permits FIFO access |
| fsel_i | input | 2 | Default-offset select strap |
| ip_i | input | 1 | Parity-layout strap for parallel words |
| sen_i | input | 1 | Serial enable, active low |
| sdi_i | input | 1 | Serial data bit |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| pdata_i | input | DATA_W | Parallel write word |
| pwr_i | input | 1 | Parallel write strobe |
| prd_i | input | 1 | Parallel read strobe |
| ae_ofs_o | output | OFS_W | Almost-empty offset |
| af_ofs_o | output | OFS_W | Almost-full offset |
| pdata_o | output | DATA_W | Parallel read-back word |
| fifo_ok_o | output | 1 | FIFO access allowed |

## Verification
The assertions check on every cycle that both offsets hold still whenever the load strobe is high. They also check that the offsets hold still in serial mode while serial enable is high, and in parallel mode whenever no write strobe arrives. They further check that the read-back bus changes only after an accepted read, that both offsets are equal right after reset, and that the access indication never rises while the load strobe is low. Only the directed scenarios can show the actual values: the default table across all eight strap codes, the bit order and wrap of the serial stream, the empty/full alternation, and the parity skipping in both directions.

// File: rtl/ofsprog_pkg.sv
package ofsprog_pkg;

   typedef enum logic {
      PROG_PAR = 1'b0,
      PROG_SER = 1'b1
   } prog_e;

   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;

   // Default offset for strap code k: 2^(k+3)-1
   function automatic logic [31:0] default_ofs(input logic [2:0] code);
      int unsigned sh;
      sh = int'(code) + 3;
      return (32'd1 << sh) - 32'd1;
   endfunction

endpackage

// File: rtl/ofsprog_serial.sv
module ofsprog_serial
   import ofsprog_pkg::*;
#(
   parameter int OFS_W = 10
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      en_i,
   input  logic                      sclk_i,
   input  logic                      sen_i,
   input  logic                      ld_i,
   output logic                      bit_we_o,
   output ofs_sel_e                  tgt_o,
   output logic [$clog2(OFS_W)-1:0]  idx_o
);
   localparam int NBITS = 2 * OFS_W;
   localparam int CNT_W = $clog2(NBITS);
   localparam int IDX_W = $clog2(OFS_W);

   logic             sclk_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;
   logic             in_full;

   assign rise     = sclk_i & ~sclk_q;
   assign bit_we_o = en_i & rise & ~sen_i & ~ld_i;
   assign in_full  = (cnt_q >= CNT_W'(OFS_W));
   assign tgt_o    = in_full ? SEL_AF : SEL_AE;
   assign idx_o    = in_full ? IDX_W'(cnt_q - CNT_W'(OFS_W)) : IDX_W'(cnt_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sclk_q <= sclk_i;
         cnt_q  <= '0;
      end else begin
         sclk_q <= sclk_i;
         if (bit_we_o) begin
            if (cnt_q == CNT_W'(NBITS - 1)) cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ofsprog_lane.sv
module ofsprog_lane #(
   parameter int OFS_W  = 10,
   parameter int DATA_W = 36
) (
   input  logic              ip_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [DATA_W-1:0] rdata_o
);
   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   for (genvar i = 0; i < OFS_W; i++) begin : g_bit
      localparam int PPOS = i + i / 8;
      assign ofs_o[i] = ip_i ? wdata_i[PPOS] : wdata_i[i];
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < OFS_W; i++) begin
         if (ip_i) rdata_o[i + i / 8] = ofs_i[i];
         else      rdata_o[i]         = ofs_i[i];
      end
   end
endmodule

// File: rtl/flag_ofs_prog.sv
module flag_ofs_prog
   import ofsprog_pkg::*;
#(
   parameter int OFS_W  = 10,
   parameter int DATA_W = 36
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ld_i,
   input  logic [1:0]        fsel_i,
   input  logic              ip_i,
   input  logic              sen_i,
   input  logic              sdi_i,
   input  logic              sclk_i,
   input  logic [DATA_W-1:0] pdata_i,
   input  logic              pwr_i,
   input  logic              prd_i,
   output logic [OFS_W-1:0]  ae_ofs_o,
   output logic [OFS_W-1:0]  af_ofs_o,
   output logic [DATA_W-1:0] pdata_o,
   output logic              fifo_ok_o
);
   localparam int SPAN  = OFS_W + (OFS_W - 1) / 8;
   localparam int IDX_W = $clog2(OFS_W);

   if (OFS_W < 4 || OFS_W > 32) begin : g_bad_ofs
      $error("flag_ofs_prog: OFS_W must lie in 4..32");
   end
   if (DATA_W < SPAN) begin : g_bad_data
      $error("flag_ofs_prog: DATA_W too narrow for the parity-skipped offset");
   end

   prog_e             prog_q;
   logic              ip_q;
   ofs_sel_e          wsel_q, rsel_q;
   logic [OFS_W-1:0]  ae_q, af_q;
   logic [DATA_W-1:0] rdata_q;

   logic              ser_we;
   ofs_sel_e          ser_tgt;
   logic [IDX_W-1:0]  ser_idx;
   logic [OFS_W-1:0]  lane_ofs;
   logic [DATA_W-1:0] lane_rdata;
   logic [OFS_W-1:0]  dflt;
   logic              par_we, rd_en;

   assign dflt   = OFS_W'(default_ofs({ld_i, fsel_i}));
   assign par_we = (prog_q == PROG_PAR) & ~ld_i & pwr_i;
   assign rd_en  = ~ld_i & prd_i;

   ofsprog_serial #(.OFS_W(OFS_W)) u_ser (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (prog_q == PROG_SER),
      .sclk_i   (sclk_i),
      .sen_i    (sen_i),
      .ld_i     (ld_i),
      .bit_we_o (ser_we),
      .tgt_o    (ser_tgt),
      .idx_o    (ser_idx)
   );

   ofsprog_lane #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_lane (
      .ip_i    (ip_q),
      .wdata_i (pdata_i),
      .ofs_i   ((rsel_q == SEL_AE) ? ae_q : af_q),
      .ofs_o   (lane_ofs),
      .rdata_o (lane_rdata)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prog_q  <= ld_i ? PROG_SER : PROG_PAR;
         ip_q    <= ip_i;
         ae_q    <= dflt;
         af_q    <= dflt;
         wsel_q  <= SEL_AE;
         rsel_q  <= SEL_AE;
         rdata_q <= '0;
      end else begin
         if (ser_we) begin
            if (ser_tgt == SEL_AF) af_q[ser_idx] <= sdi_i;
            else                   ae_q[ser_idx] <= sdi_i;
         end
         if (par_we) begin
            if (wsel_q == SEL_AE) begin
               ae_q   <= lane_ofs;
               wsel_q <= SEL_AF;
            end else begin
               af_q   <= lane_ofs;
               wsel_q <= SEL_AE;
            end
         end
         if (rd_en) begin
            rdata_q <= lane_rdata;
            rsel_q  <= (rsel_q == SEL_AE) ? SEL_AF : SEL_AE;
         end
      end
   end

   assign ae_ofs_o  = ae_q;
   assign af_ofs_o  = af_q;
   assign pdata_o   = rdata_q;
   assign fifo_ok_o = ld_i & ~rst_i;
endmodule

// File: rtl/flag_ofs_prog_chk.sv
module flag_ofs_prog_chk
   import ofsprog_pkg::*;
#(
   parameter int OFS_W  = 10,
   parameter int DATA_W = 36
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              ld_i,
   input logic              sen_i,
   input logic              pwr_i,
   input logic              prd_i,
   input prog_e             prog_q,
   input logic [OFS_W-1:0]  ae_ofs_o,
   input logic [OFS_W-1:0]  af_ofs_o,
   input logic [DATA_W-1:0] pdata_o,
   input logic              fifo_ok_o
);
   a_r1_defaults_equal: assert property (@(posedge clk_i)
      rst_i |=> (ae_ofs_o == af_ofs_o));

   a_r10_fifo_ok_needs_ld: assert property (@(posedge clk_i)
      fifo_ok_o |-> (ld_i && !rst_i));

   a_r5_hold_while_ld_high: assert property (@(posedge clk_i) disable iff (rst_i)
      ld_i |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

   a_r5_hold_while_sen_high: assert property (@(posedge clk_i) disable iff (rst_i)
      (prog_q == PROG_SER && sen_i) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

   a_r2_par_needs_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      (prog_q == PROG_PAR && !pwr_i) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

   a_r8_readback_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (ld_i || !prd_i) |=> $stable(pdata_o));
endmodule

bind flag_ofs_prog flag_ofs_prog_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .ld_i      (ld_i),
   .sen_i     (sen_i),
   .pwr_i     (pwr_i),
   .prd_i     (prd_i),
   .prog_q    (prog_q),
   .ae_ofs_o  (ae_ofs_o),
   .af_ofs_o  (af_ofs_o),
   .pdata_o   (pdata_o),
   .fifo_ok_o (fifo_ok_o)
);

// File: tb/tb_flag_ofs_prog.sv
module tb_flag_ofs_prog;
   localparam int CLK_PERIOD = 10;
   localparam int OFS_W  = 10;
   localparam int DATA_W = 36;

   logic              clk = 1'b0;
   logic              rst_i = 1'b1;
   logic              ld_i = 1'b1;
   logic [1:0]        fsel_i = 2'b00;
   logic              ip_i = 1'b0;
   logic              sen_i = 1'b1;
   logic              sdi_i = 1'b0;
   logic              sclk_i = 1'b0;
   logic [DATA_W-1:0] pdata_i = '0;
   logic              pwr_i = 1'b0;
   logic              prd_i = 1'b0;
   logic [OFS_W-1:0]  ae_ofs_o, af_ofs_o;
   logic [DATA_W-1:0] pdata_o;
   logic              fifo_ok_o;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flag_ofs_prog #(.OFS_W(OFS_W), .DATA_W(DATA_W)) dut (
      .clk_i(clk), .rst_i(rst_i), .ld_i(ld_i), .fsel_i(fsel_i), .ip_i(ip_i),
      .sen_i(sen_i), .sdi_i(sdi_i), .sclk_i(sclk_i), .pdata_i(pdata_i),
      .pwr_i(pwr_i), .prd_i(prd_i), .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o),
      .pdata_o(pdata_o), .fifo_ok_o(fifo_ok_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Place an offset on the parallel bus per the R7 layout
   function automatic logic [DATA_W-1:0] place(input logic [OFS_W-1:0] v, input logic ip);
      logic [DATA_W-1:0] d = '0;
      for (int i = 0; i < OFS_W; i++) d[ip ? i + i / 8 : i] = v[i];
      return d;
   endfunction

   task automatic do_reset(input logic ld, input logic [1:0] fs, input logic ip);
      tick();
      rst_i = 1'b1; ld_i = ld; fsel_i = fs; ip_i = ip;
      sen_i = 1'b1; pwr_i = 1'b0; prd_i = 1'b0; sclk_i = 1'b0;
      tick();
      check("R10 reset blocks access", 64'(fifo_ok_o), 64'd0);
      tick();
      rst_i = 1'b0; ld_i = 1'b1; ip_i = 1'b0; fsel_i = 2'b00;
      tick();
   endtask

   task automatic ser_bit(input logic b);
      sdi_i = b; sclk_i = 1'b1;
      tick();
      sclk_i = 1'b0;
      tick();
   endtask

   task automatic par_write(input logic [DATA_W-1:0] d);
      pdata_i = d; pwr_i = 1'b1;
      tick();
      pwr_i = 1'b0; pdata_i = '0;
      tick();
   endtask

   task automatic par_read();
      prd_i = 1'b1;
      tick();
      prd_i = 1'b0;
   endtask

   task automatic t_defaults();
      for (int k = 0; k < 8; k++) begin
         logic [OFS_W-1:0] e;
         e = OFS_W'((64'd1 << (k + 3)) - 1);
         do_reset(k[2], k[1:0], 1'b0);
         check("R1 default empty offset", 64'(ae_ofs_o), 64'(e));
         check("R1 default full offset", 64'(af_ofs_o), 64'(e));
      end
      check("R10 access allowed with ld high", 64'(fifo_ok_o), 64'd1);
   endtask

   task automatic t_serial();
      logic [OFS_W-1:0] ev = 10'h155, fv = 10'h2CA;
      do_reset(1'b1, 2'b00, 1'b0);
      ld_i = 1'b0; sen_i = 1'b0;
      tick();
      check("R10 no access with ld low", 64'(fifo_ok_o), 64'd0);
      for (int i = 0; i < OFS_W; i++) ser_bit(ev[i]);
      check("R3 empty filled first", 64'(ae_ofs_o), 64'(ev));
      check("R3 full untouched so far", 64'(af_ofs_o), 64'd127);
      for (int i = 0; i < OFS_W; i++) ser_bit(fv[i]);
      check("R3 full filled second", 64'(af_ofs_o), 64'(fv));
      ser_bit(1'b0);
      check("R4 wrap to empty bit 0", 64'(ae_ofs_o), 64'(ev & ~10'h1));
      check("R4 full kept on wrap", 64'(af_ofs_o), 64'(fv));
      sen_i = 1'b1;
      for (int i = 0; i < 4; i++) ser_bit(1'b1);
      check("R5 sen high holds empty", 64'(ae_ofs_o), 64'(ev & ~10'h1));
      sen_i = 1'b0; ld_i = 1'b1;
      for (int i = 0; i < 4; i++) ser_bit(1'b1);
      check("R5 ld high holds empty", 64'(ae_ofs_o), 64'(ev & ~10'h1));
      ld_i = 1'b0; sen_i = 1'b1;
      par_write(64'h3FF);
      check("R2 serial mode ignores parallel write", 64'(ae_ofs_o), 64'(ev & ~10'h1));
      par_read();
      check("R8 read-back in serial mode", 64'(pdata_o), 64'(ev & ~10'h1));
      ld_i = 1'b1;
   endtask

   task automatic t_parallel();
      do_reset(1'b0, 2'b01, 1'b0);
      ld_i = 1'b0;
      par_write({26'h3ABCDEF, 10'h3AB});
      check("R6 first write to empty", 64'(ae_ofs_o), 64'h3AB);
      check("R6 full untouched", 64'(af_ofs_o), 64'd15);
      par_write({26'h1555555, 10'h0F1});
      check("R7 upper bits ignored, full written", 64'(af_ofs_o), 64'h0F1);
      sen_i = 1'b0;
      for (int i = 0; i < 3; i++) ser_bit(1'b0);
      check("R2 parallel mode ignores serial", 64'(ae_ofs_o), 64'h3AB);
      sen_i = 1'b1; ld_i = 1'b1;
      par_write(36'h000000011);
      check("R6 ld high blocks write", 64'(ae_ofs_o), 64'h3AB);
      par_read();
      check("R8 ld high blocks read", 64'(pdata_o), 64'd0);
      ld_i = 1'b0;
      par_read();
      check("R8 first read gives empty", 64'(pdata_o), 64'(place(10'h3AB, 1'b0)));
      par_read();
      check("R8 second read gives full", 64'(pdata_o), 64'(place(10'h0F1, 1'b0)));
      par_write(36'h000000022);
      check("R6 third write back to empty", 64'(ae_ofs_o), 64'h022);
      ld_i = 1'b1;
   endtask

   task automatic t_parity();
      logic [DATA_W-1:0] pbits;
      pbits = (36'd1 << 8) | (36'd1 << 17) | (36'd1 << 26) | (36'd1 << 35);
      do_reset(1'b0, 2'b10, 1'b1);
      ld_i = 1'b0;
      par_write(place(10'h2A5, 1'b1) | pbits);
      check("R7 parity bits skipped", 64'(ae_ofs_o), 64'h2A5);
      par_write(place(10'h17F, 1'b1));
      check("R7 parity layout full", 64'(af_ofs_o), 64'h17F);
      par_read();
      check("R8 parity layout read-back", 64'(pdata_o), 64'(place(10'h2A5, 1'b1)));
      ld_i = 1'b1;
   endtask

   task automatic t_reset_ptrs();
      do_reset(1'b0, 2'b00, 1'b0);
      ld_i = 1'b0;
      par_write(36'h0AA);
      par_read();
      do_reset(1'b0, 2'b00, 1'b0);
      ld_i = 1'b0;
      par_write(36'h055);
      check("R9 write pointer back at empty", 64'(ae_ofs_o), 64'h055);
      check("R9 full keeps default", 64'(af_ofs_o), 64'd7);
      par_read();
      check("R9 read pointer back at empty", 64'(pdata_o), 64'h055);
      do_reset(1'b1, 2'b00, 1'b0);
      ld_i = 1'b0; sen_i = 1'b0;
      for (int i = 0; i < 13; i++) ser_bit(1'b0);
      do_reset(1'b1, 2'b00, 1'b0);
      ld_i = 1'b0; sen_i = 1'b0;
      ser_bit(1'b0);
      check("R9 serial count restarts at empty bit 0", 64'(ae_ofs_o), 64'd126);
      check("R9 serial full untouched", 64'(af_ofs_o), 64'd127);
      sen_i = 1'b1; ld_i = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_defaults();
      t_serial();
      t_parallel();
      t_parity();
      t_reset_ptrs();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule